// File: doc/BRIEF.md
# Two-Channel Converter Data Holding Controller

This block is the digital front end of a pair of 12-bit digital-to-analog converters. A host writes sample data over a simple register bus into a holding register per channel. It can use one of three alignment formats. It can also use a combined register that loads both channels in a single access. Each channel then copies its held code into an output register. The code on that output register drives the converter.

The copy happens in one of two ways. When triggering is off, it follows the write automatically. When triggering is on, it waits for a selected event: an external line, one of the timer trigger lines, or a self-clearing software trigger bit. Hardware events can also raise a DMA request, which stays up until acknowledged. An event that arrives while a request is still pending is recorded as an underrun, and the underrun can raise an interrupt. The analog converter itself is outside this block.

Top module: `dac_hold_ctrl`

## Requirements
- R1: Each channel has three holding addresses: 12-bit right-aligned (ch1 0x08, ch2 0x14), code = data[11:0]; 12-bit left-aligned (ch1 0x0C, ch2 0x18), code = data[15:4]; 8-bit right-aligned (ch1 0x10, ch2 0x1C), code = {data[7:0], 4'b0000}. Other data bits are ignored.
- R2: One write to a dual address loads both channels. At 0x20 (12-bit right), ch1 takes data[11:0] and ch2 takes data[27:16]. At 0x24 (12-bit left), ch1 takes data[15:4] and ch2 takes data[31:20]. At 0x28 (8-bit), ch1 takes data[7:0] and ch2 takes data[15:8], each shifted left by 4.
- R3: With a channel enabled and its trigger enable clear, the output code equals the newly held code on the clock edge after the holding write. A disabled channel never changes its output code.
- R4: With trigger enable set, a holding write alone does not change the output. A rising edge on the selected line updates the output on the third clock edge that samples the line high. Trigger select 0 is the external line, 1 to 6 are timer lines 0 to 5, and 7 is software. Unselected lines have no effect.
- R5: Writing 1 to bit c of the software-trigger register (0x04; bit 0 is ch1, bit 1 is ch2) updates that channel on the next edge if its trigger select is 7. The bit reads 1 for one cycle and then reads 0. Writing 3 fires both channels. When the select is not 7, the bit has no effect on the output.
- R6: A hardware-triggered update raises dma_req[c] if the channel's DMA enable is set. The request stays high until dma_ack[c] is sampled high. A software trigger never raises it.
- R7: A hardware-triggered update while dma_req[c] is pending and not being acknowledged sets the channel's underrun flag. The flag is status register 0x34, bit 13 for ch1 and bit 29 for ch2. Writing 1 to the flag bit clears it; writing 0 leaves it set.
- R8: irq is high exactly when some channel has both its underrun flag and its underrun interrupt enable set.
- R9: The control register is at 0x00. Ch1 fields are: bit 0 enable, bit 1 trigger enable, bits 4:2 trigger select, bit 12 DMA enable, bit 13 underrun interrupt enable. Ch2 uses the same fields shifted up by 16. A control write leaves the trigger select unchanged while the channel is currently enabled.
- R10: After reset, both output codes, the control register, dma_req and irq are zero.
- R11: Reads of 0x2C (ch1) and 0x30 (ch2) return the channel's output code, zero-extended to 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ext_trig | input | 1 | External trigger line |
| tim_trig | input | 6 | Timer trigger lines |
| dma_ack | input | 2 | DMA acknowledge per channel |
| dma_req | output | 2 | DMA request per channel |
| irq | output | 1 | Underrun interrupt |
| dac_code1 | output | 12 | Channel 1 output code |
| dac_code2 | output | 12 | Channel 2 output code |

## Verification
The underrun is the hardest state to reach from the ports. It needs DMA enabled, a first hardware edge that leaves a request hanging, and then a fresh rising edge on the same selected line before any acknowledge arrives. The bench drops the line for one sampled cycle and raises it again while withholding dma_ack. It then toggles the interrupt enable and clears the flag, checking that irq follows. The format paths are swept over every code value with junk in the ignored bits. The trigger path is walked through all seven sources, and each one is also pulsed on a neighbouring line that must not fire.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int CODE_W = 12;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;
  localparam int NCH    = 2;
  localparam int TSEL_W = 3;
  localparam int CH_SPAN = 16;

  localparam logic [TSEL_W-1:0] TSEL_EXT = 3'd0;
  localparam logic [TSEL_W-1:0] TSEL_SW  = 3'd7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_SWTRIG = 6'h04;
  localparam int                A_HOLD0  = 8;
  localparam int                HOLD_STEP = 12;
  localparam logic [ADDR_W-1:0] A_DUAL_R12 = 6'h20;
  localparam logic [ADDR_W-1:0] A_DUAL_L12 = 6'h24;
  localparam logic [ADDR_W-1:0] A_DUAL_R8  = 6'h28;
  localparam logic [ADDR_W-1:0] A_OUT1   = 6'h2C;
  localparam logic [ADDR_W-1:0] A_OUT2   = 6'h30;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h34;

  localparam int B_EN   = 0;
  localparam int B_TEN  = 1;
  localparam int B_TSEL = 2;
  localparam int B_DMA  = 12;
  localparam int B_UIE  = 13;

  typedef enum logic [1:0] {FMT_R12, FMT_L12, FMT_R8} fmt_e;

  typedef struct packed {
    logic              en;
    logic              ten;
    logic [TSEL_W-1:0] tsel;
    logic              dma_en;
    logic              udr_ie;
  } ch_cfg_t;

  function automatic logic [CODE_W-1:0] align_code(fmt_e f, logic [15:0] v);
    case (f)
      FMT_R12: return v[CODE_W-1:0];
      FMT_L12: return v[15 -: CODE_W];
      default: return {v[7:0], {(CODE_W-8){1'b0}}};
    endcase
  endfunction
endpackage

// File: rtl/dac_wr_decode.sv
module dac_wr_decode
  import dac_pkg::*;
(
  input  logic                          bus_we,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [NCH-1:0]                hold_we,
  output logic [NCH-1:0][CODE_W-1:0]    hold_code,
  output logic                          ctrl_we,
  output logic                          sw_we,
  output logic                          stat_we
);
  always_comb begin
    hold_we   = '0;
    hold_code = '0;
    ctrl_we   = 1'b0;
    sw_we     = 1'b0;
    stat_we   = 1'b0;
    if (bus_we) begin
      ctrl_we = (bus_addr == A_CTRL);
      sw_we   = (bus_addr == A_SWTRIG);
      stat_we = (bus_addr == A_STAT);
      // per-channel single writes: three formats at consecutive words
      for (int c = 0; c < NCH; c++) begin
        if (bus_addr == ADDR_W'(A_HOLD0 + HOLD_STEP*c)) begin
          hold_we[c]   = 1'b1;
          hold_code[c] = align_code(FMT_R12, bus_wdata[15:0]);
        end
        if (bus_addr == ADDR_W'(A_HOLD0 + HOLD_STEP*c + 4)) begin
          hold_we[c]   = 1'b1;
          hold_code[c] = align_code(FMT_L12, bus_wdata[15:0]);
        end
        if (bus_addr == ADDR_W'(A_HOLD0 + HOLD_STEP*c + 8)) begin
          hold_we[c]   = 1'b1;
          hold_code[c] = align_code(FMT_R8, bus_wdata[15:0]);
        end
      end
      // combined writes load both channels at once
      if (bus_addr == A_DUAL_R12) begin
        hold_we      = '1;
        hold_code[0] = align_code(FMT_R12, bus_wdata[15:0]);
        hold_code[1] = align_code(FMT_R12, bus_wdata[31:16]);
      end
      if (bus_addr == A_DUAL_L12) begin
        hold_we      = '1;
        hold_code[0] = align_code(FMT_L12, bus_wdata[15:0]);
        hold_code[1] = align_code(FMT_L12, bus_wdata[31:16]);
      end
      if (bus_addr == A_DUAL_R8) begin
        hold_we      = '1;
        hold_code[0] = align_code(FMT_R8, {8'h00, bus_wdata[7:0]});
        hold_code[1] = align_code(FMT_R8, {8'h00, bus_wdata[15:8]});
      end
    end
  end
endmodule

// File: rtl/dac_trig_detect.sv
module dac_trig_detect
  import dac_pkg::*;
#(
  parameter int NUM_TIM = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ext_trig,
  input  logic [NUM_TIM-1:0] tim_trig,
  input  logic [TSEL_W-1:0]  tsel,
  input  logic               arm,
  output logic               fire
);
  logic sel_line;
  logic s1_q, s2_q, fire_q;
  logic fire_d;

  always_comb begin
    sel_line = 1'b0;
    if (tsel == TSEL_EXT) sel_line = ext_trig;
    for (int i = 0; i < NUM_TIM; i++) begin
      if (int'(tsel) == i + 1) sel_line = tim_trig[i];
    end
  end

  // rising edge seen on the second stage, registered once more
  always_comb fire_d = s1_q & ~s2_q & arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      s1_q   <= sel_line;
      s2_q   <= s1_q;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_pkg::*;
#(
  parameter int NUM_TIM = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               ten,
  input  logic [TSEL_W-1:0]  tsel,
  input  logic               dma_en,
  input  logic               hold_we,
  input  logic [CODE_W-1:0]  hold_code,
  input  logic               sw_pulse,
  input  logic               ext_trig,
  input  logic [NUM_TIM-1:0] tim_trig,
  input  logic               dma_ack,
  input  logic               udr_clr,
  output logic [CODE_W-1:0]  out_code,
  output logic               dma_req,
  output logic               udr_flag
);
  logic [CODE_W-1:0] hold_q, out_q;
  logic ld_q, req_q, udr_q;
  logic req_d, udr_d;
  logic arm, hw_fire, hw_xfer, sw_xfer, xfer;

  always_comb arm = en & ten & (tsel != TSEL_SW);

  dac_trig_detect #(.NUM_TIM(NUM_TIM)) u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_trig (ext_trig),
    .tim_trig (tim_trig),
    .tsel     (tsel),
    .arm      (arm),
    .fire     (hw_fire)
  );

  always_comb begin
    hw_xfer = hw_fire & arm;
    sw_xfer = sw_pulse & en & ten & (tsel == TSEL_SW);
    xfer    = (en & ~ten & ld_q) | hw_xfer | sw_xfer;
    req_d   = (req_q & ~dma_ack) | (hw_xfer & dma_en);
    udr_d   = (udr_q & ~udr_clr) | (hw_xfer & req_q & ~dma_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      out_q  <= '0;
      ld_q   <= 1'b0;
      req_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      if (hold_we) hold_q <= hold_code;
      if (xfer)    out_q  <= hold_q;
      ld_q  <= hold_we;
      req_q <= req_d;
      udr_q <= udr_d;
    end
  end

  assign out_code = out_q;
  assign dma_req  = req_q;
  assign udr_flag = udr_q;
endmodule

// File: rtl/dac_hold_ctrl.sv
module dac_hold_ctrl
  import dac_pkg::*;
#(
  parameter int NUM_TIM = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [5:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic               ext_trig,
  input  logic [NUM_TIM-1:0] tim_trig,
  input  logic [1:0]         dma_ack,
  output logic [1:0]         dma_req,
  output logic               irq,
  output logic [11:0]        dac_code1,
  output logic [11:0]        dac_code2
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [NCH-1:0]             hold_we;
  logic [NCH-1:0][CODE_W-1:0] hold_code;
  logic                       ctrl_we, sw_we, stat_we;

  dac_wr_decode u_dec (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .hold_we   (hold_we),
    .hold_code (hold_code),
    .ctrl_we   (ctrl_we),
    .sw_we     (sw_we),
    .stat_we   (stat_we)
  );

  ch_cfg_t [NCH-1:0]          cfg_q, cfg_d;
  logic [NCH-1:0]             sw_q, sw_d;
  logic [NCH-1:0]             udr_clr;
  logic [NCH-1:0][CODE_W-1:0] code_v;
  logic [NCH-1:0]             udr_v, en_v, dmaen_v;
  logic [NCH*TSEL_W-1:0]      tsel_v;
  logic [DATA_W-1:0]          ctrl_rd, stat_rd;

  always_comb begin
    cfg_d = cfg_q;
    for (int c = 0; c < NCH; c++) begin
      if (ctrl_we) begin
        cfg_d[c].en     = bus_wdata[CH_SPAN*c + B_EN];
        cfg_d[c].ten    = bus_wdata[CH_SPAN*c + B_TEN];
        cfg_d[c].dma_en = bus_wdata[CH_SPAN*c + B_DMA];
        cfg_d[c].udr_ie = bus_wdata[CH_SPAN*c + B_UIE];
        // select frozen while the channel runs
        if (!cfg_q[c].en)
          cfg_d[c].tsel = bus_wdata[CH_SPAN*c + B_TSEL +: TSEL_W];
      end
      sw_d[c]    = sw_we & bus_wdata[c];
      udr_clr[c] = stat_we & bus_wdata[CH_SPAN*c + B_UIE];
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      cfg_q <= '0;
      sw_q  <= '0;
    end else begin
      if (ctrl_we) cfg_q <= cfg_d;
      sw_q <= sw_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dac_chan #(.NUM_TIM(NUM_TIM)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .en        (cfg_q[c].en),
      .ten       (cfg_q[c].ten),
      .tsel      (cfg_q[c].tsel),
      .dma_en    (cfg_q[c].dma_en),
      .hold_we   (hold_we[c]),
      .hold_code (hold_code[c]),
      .sw_pulse  (sw_q[c]),
      .ext_trig  (ext_trig),
      .tim_trig  (tim_trig),
      .dma_ack   (dma_ack[c]),
      .udr_clr   (udr_clr[c]),
      .out_code  (code_v[c]),
      .dma_req   (dma_req[c]),
      .udr_flag  (udr_v[c])
    );
    assign en_v[c]                    = cfg_q[c].en;
    assign dmaen_v[c]                 = cfg_q[c].dma_en;
    assign tsel_v[TSEL_W*c +: TSEL_W] = cfg_q[c].tsel;
  end

  always_comb begin
    ctrl_rd = '0;
    stat_rd = '0;
    irq     = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      ctrl_rd[CH_SPAN*c + B_EN]               = cfg_q[c].en;
      ctrl_rd[CH_SPAN*c + B_TEN]              = cfg_q[c].ten;
      ctrl_rd[CH_SPAN*c + B_TSEL +: TSEL_W]   = cfg_q[c].tsel;
      ctrl_rd[CH_SPAN*c + B_DMA]              = cfg_q[c].dma_en;
      ctrl_rd[CH_SPAN*c + B_UIE]              = cfg_q[c].udr_ie;
      stat_rd[CH_SPAN*c + B_UIE]              = udr_v[c];
      irq = irq | (udr_v[c] & cfg_q[c].udr_ie);
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:   bus_rdata = ctrl_rd;
      A_SWTRIG: bus_rdata = {{(DATA_W-NCH){1'b0}}, sw_q};
      A_OUT1:   bus_rdata = {{(DATA_W-CODE_W){1'b0}}, code_v[0]};
      A_OUT2:   bus_rdata = {{(DATA_W-CODE_W){1'b0}}, code_v[1]};
      A_STAT:   bus_rdata = stat_rd;
      default:  bus_rdata = '0;
    endcase
  end

  assign dac_code1 = code_v[0];
  assign dac_code2 = code_v[1];
endmodule

// File: rtl/dac_hold_ctrl_chk.sv
module dac_hold_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  dma_req,
  input logic [1:0]  dma_ack,
  input logic        irq,
  input logic [1:0]  ch_en,
  input logic [1:0]  dma_en,
  input logic [5:0]  tsel,
  input logic [1:0]  udr,
  input logic [11:0] code1,
  input logic [11:0] code2
);
  for (genvar c = 0; c < 2; c++) begin : g_c
    assert_req_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req[c] && !dma_ack[c]) |=> dma_req[c]);
    assert_req_needs_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req[c]) |-> dma_en[c]);
    assert_udr_needs_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(udr[c]) |-> $past(dma_req[c]));
    assert_tsel_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ch_en[c]) |-> $stable(tsel[3*c +: 3]));
  end

  assert_hold_off1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ch_en[0]) |-> $stable(code1));
  assert_hold_off2_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!ch_en[1]) |-> $stable(code2));
  assert_irq_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (udr != 2'b00));
endmodule

bind dac_hold_ctrl dac_hold_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .dma_req (dma_req),
  .dma_ack (dma_ack),
  .irq     (irq),
  .ch_en   (en_v),
  .dma_en  (dmaen_v),
  .tsel    (tsel_v),
  .udr     (udr_v),
  .code1   (dac_code1),
  .code2   (dac_code2)
);

// File: tb/test_dac_hold_ctrl.sv
`timescale 1ns/1ps
module test_dac_hold_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        ext_trig;
  logic [5:0]  tim_trig;
  logic [1:0]  dma_ack;
  logic [1:0]  dma_req;
  logic        irq;
  logic [11:0] dac_code1, dac_code2;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dac_hold_ctrl i_dac_hold_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_trig(ext_trig),
    .tim_trig(tim_trig), .dma_ack(dma_ack), .dma_req(dma_req), .irq(irq),
    .dac_code1(dac_code1), .dac_code2(dac_code2)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic set_line(int idx, logic v);
    if (idx == 0) ext_trig = v;
    else tim_trig[idx-1] = v;
  endtask

  function automatic logic [31:0] cw(bit en, bit ten, int ts, bit dm, bit ie);
    return 32'(en) | (32'(ten) << 1) | (32'(ts) << 2) | (32'(dm) << 12) | (32'(ie) << 13);
  endfunction

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [11:0] p1, p2;
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    ext_trig = 1'b0; tim_trig = '0; dma_ack = '0;
    tick(3);
    rst_n = 1'b1;
    tick(3);

    // R10 reset state
    chk("R10 code1", 32'(dac_code1), 0);
    chk("R10 code2", 32'(dac_code2), 0);
    rd(6'h00, d); chk("R10 ctrl", d, 0);
    chk("R10 dma_req", 32'(dma_req), 0);
    chk("R10 irq", 32'(irq), 0);
    rd(6'h2C, d); chk("R11 out1 reset", d, 0);

    wr(6'h00, cw(1,0,0,0,0) | (cw(1,0,0,0,0) << 16));
    // R3 latency: not yet after the write edge, present one edge later
    wr(6'h08, 32'h5A5);
    chk("R3 before", 32'(dac_code1), 0);
    tick(1);
    chk("R3 after", 32'(dac_code1), 32'h5A5);

    // R1 12-bit right, all codes, junk in ignored bits
    for (int v = 0; v < 4096; v++) begin
      wr(6'h08, 32'h5A5A_0000 | (32'((v*3) & 15) << 12) | 32'(v));
      tick(1);
      chk("R1 r12 ch1", 32'(dac_code1), 32'(v));
      if (v % 512 == 0) begin
        rd(6'h2C, d); chk("R11 out1", d, 32'(v));
      end
    end
    // R1 8-bit right ch2
    for (int v = 0; v < 256; v++) begin
      wr(6'h1C, 32'hABCD_EF00 | 32'(v));
      tick(1);
      chk("R1 r8 ch2", 32'(dac_code2), 32'(v) << 4);
      if (v % 64 == 0) begin
        rd(6'h30, d); chk("R11 out2", d, 32'(v) << 4);
      end
    end
    // R1 12-bit left ch1
    for (int v = 0; v < 4096; v++) begin
      wr(6'h0C, (32'(v) << 4) | 32'(v & 15));
      tick(1);
      chk("R1 l12 ch1", 32'(dac_code1), 32'(v));
    end
    // R1 other channel formats
    wr(6'h14, 32'hF000_0ABC); tick(1); chk("R1 r12 ch2", 32'(dac_code2), 32'hABC);
    wr(6'h18, 32'h0000_DEF7); tick(1); chk("R1 l12 ch2", 32'(dac_code2), 32'hDEF);
    wr(6'h10, 32'h0000_FF3C); tick(1); chk("R1 r8 ch1", 32'(dac_code1), 32'h3C0);

    // R2 dual writes
    for (int p = 0; p < 64; p++) begin
      int a, b, a8, b8;
      a = (p*131 + 7) & 12'hFFF; b = (p*517 + 3) & 12'hFFF;
      a8 = (p*37) & 8'hFF; b8 = (p*91 + 5) & 8'hFF;
      wr(6'h20, (32'(b) << 16) | 32'(a) | 32'hF000_F000);
      tick(1);
      chk("R2 r12 ch1", 32'(dac_code1), 32'(a));
      chk("R2 r12 ch2", 32'(dac_code2), 32'(b));
      wr(6'h24, (32'(a) << 20) | (32'(b) << 4));
      tick(1);
      chk("R2 l12 ch1", 32'(dac_code1), 32'(b));
      chk("R2 l12 ch2", 32'(dac_code2), 32'(a));
      wr(6'h28, (32'(b8) << 8) | 32'(a8) | 32'hFFFF_0000);
      tick(1);
      chk("R2 r8 ch1", 32'(dac_code1), 32'(a8) << 4);
      chk("R2 r8 ch2", 32'(dac_code2), 32'(b8) << 4);
    end

    // R3 disabled channel holds
    wr(6'h00, cw(1,0,0,0,0));
    p2 = dac_code2;
    wr(6'h14, 32'h555);
    tick(3);
    chk("R3 disabled ch2", 32'(dac_code2), 32'(p2));

    // R4 each trigger source, plus a neighbouring line that must not fire
    for (int s = 0; s < 7; s++) begin
      int val, other;
      val = (100 + s*311) & 12'hFFF;
      other = (s + 1) % 7;
      wr(6'h00, 0);
      wr(6'h00, cw(1,1,s,0,0));
      p1 = dac_code1;
      wr(6'h08, 32'(val));
      tick(2);
      chk("R4 hold no pass", 32'(dac_code1), 32'(p1));
      set_line(other, 1'b1);
      tick(4);
      chk("R4 unselected", 32'(dac_code1), 32'(p1));
      set_line(other, 1'b0);
      tick(1);
      set_line(s, 1'b1);
      tick(2);
      chk("R4 two edges", 32'(dac_code1), 32'(p1));
      tick(1);
      chk("R4 third edge", 32'(dac_code1), 32'(val));
      set_line(s, 1'b0);
      tick(1);
    end

    // R9 select lock (currently enabled with select 6)
    wr(6'h00, cw(1,1,2,0,0));
    rd(6'h00, d); chk("R9 locked", (d >> 2) & 7, 6);
    wr(6'h00, cw(0,1,2,0,0));
    rd(6'h00, d); chk("R9 locked on disable write", (d >> 2) & 7, 6);
    wr(6'h00, cw(0,1,2,0,0));
    rd(6'h00, d); chk("R9 free when disabled", (d >> 2) & 7, 2);

    // R5 software trigger
    wr(6'h00, cw(1,1,7,0,0) | (cw(1,1,7,0,0) << 16));
    wr(6'h08, 32'h3A5);
    wr(6'h14, 32'h6C9);
    tick(2);
    p1 = dac_code1; p2 = dac_code2;
    wr(6'h04, 32'h1);
    rd(6'h04, d); chk("R5 bit set", d, 1);
    chk("R5 before", 32'(dac_code1), 32'(p1));
    tick(1);
    chk("R5 ch1 fired", 32'(dac_code1), 32'h3A5);
    rd(6'h04, d); chk("R5 bit cleared", d, 0);
    chk("R5 ch2 untouched", 32'(dac_code2), 32'(p2));
    chk("R6 no sw dma", 32'(dma_req), 0);
    wr(6'h08, 32'h111);
    wr(6'h14, 32'h222);
    wr(6'h04, 32'h3);
    tick(1);
    chk("R5 dual ch1", 32'(dac_code1), 32'h111);
    chk("R5 dual ch2", 32'(dac_code2), 32'h222);
    // software bit ignored in hardware mode
    wr(6'h00, 0);
    wr(6'h00, cw(1,1,0,1,1));
    wr(6'h08, 32'h777);
    wr(6'h04, 32'h1);
    tick(2);
    chk("R5 ignored", 32'(dac_code1), 32'h111);
    chk("R6 ignored no dma", 32'(dma_req), 0);

    // R6 request and acknowledge
    set_line(0, 1'b1);
    tick(3);
    chk("R4 ext fire", 32'(dac_code1), 32'h777);
    chk("R6 req raised", 32'(dma_req), 1);
    set_line(0, 1'b0);
    tick(3);
    chk("R6 req held", 32'(dma_req), 1);
    dma_ack = 2'b01;
    tick(1);
    dma_ack = 2'b00;
    chk("R6 req acked", 32'(dma_req), 0);

    // R7 underrun, R8 irq
    set_line(0, 1'b1);
    tick(3);
    chk("R6 req again", 32'(dma_req), 1);
    chk("R8 irq low", 32'(irq), 0);
    set_line(0, 1'b0);
    tick(1);
    set_line(0, 1'b1);
    tick(3);
    rd(6'h34, d); chk("R7 flag set", d, 32'h2000);
    chk("R8 irq high", 32'(irq), 1);
    set_line(0, 1'b0);
    tick(1);
    wr(6'h00, cw(1,1,0,1,0));
    chk("R8 irq masked", 32'(irq), 0);
    rd(6'h34, d); chk("R7 flag sticky", d, 32'h2000);
    wr(6'h00, cw(1,1,0,1,1));
    chk("R8 irq unmasked", 32'(irq), 1);
    wr(6'h34, 32'h0);
    rd(6'h34, d); chk("R7 write0 keeps", d, 32'h2000);
    wr(6'h34, 32'h2000);
    rd(6'h34, d); chk("R7 w1c", d, 0);
    chk("R8 irq cleared", 32'(irq), 0);
    dma_ack = 2'b01;
    tick(1);
    dma_ack = 2'b00;

    // R6 no request without DMA enable
    wr(6'h00, cw(1,1,0,0,0));
    wr(6'h08, 32'h0F0);
    set_line(0, 1'b1);
    tick(3);
    chk("R4 ext fire nodma", 32'(dac_code1), 32'h0F0);
    chk("R6 no req without en", 32'(dma_req), 0);
    set_line(0, 1'b0);
    tick(1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule